// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two 8-bit buses, called A and B, and moves data in one direction at a time. Each direction has its own capture register with its own clock. The A-side register samples bus A on a rising edge of the A-to-B clock. The B-side register samples bus B on a rising edge of the B-to-A clock. Capture happens on every rising edge, whatever the output controls are doing.

An active-low output enable and a direction input decide which bus the block drives. With the enable high, neither bus is driven. With the enable low and the direction low, bus A is driven from B. With the enable low and the direction high, bus B is driven from A. For each direction, a select input picks either live data from the opposite bus or the value held in that direction's register.

The outputs are open-collector. Each bit is a pull-low enable, so a driven bit either pulls its line low or releases it, and a high level comes only from an external pull-up. Each bus is split into an input vector and a pull-enable vector, so there are no internal tristates. An elaboration parameter chooses a non-inverting or an inverting data path. An asynchronous active-low reset clears both registers. Its release is synchronised separately into each register's clock domain.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While `oe_n` is 1 (isolation), `a_pull` and `b_pull` are all zero.
- R2: With `oe_n`=0, `dir`=0 and `sel_ba`=0, `a_pull[i]` is 1 exactly when `b_in[i]` XOR INVERT is 0 (live B drives A), and `b_pull` is all zero.
- R3: With `oe_n`=0, `dir`=0 and `sel_ba`=1, `a_pull[i]` is 1 exactly when bit i of the B-side register XOR INVERT is 0 (stored B drives A).
- R4: With `oe_n`=0, `dir`=1 and `sel_ab`=0, `b_pull[i]` is 1 exactly when `a_in[i]` XOR INVERT is 0 (live A drives B), and `a_pull` is all zero.
- R5: With `oe_n`=0, `dir`=1 and `sel_ab`=1, `b_pull[i]` is 1 exactly when bit i of the A-side register XOR INVERT is 0 (stored A drives B).
- R6: `a_pull` and `b_pull` are never both non-zero in the same cycle.
- R7: A rising edge of `clk_ab` loads `a_in` into the A-side register, and a rising edge of `clk_ba` loads `b_in` into the B-side register, whatever the values of `oe_n`, `dir`, `sel_ab` and `sel_ba`.
- R8: Values captured while `oe_n`=1 are the values later shown by the stored-data modes (R3, R5).
- R9: While `rst_n` is 0, both registers read zero. After `rst_n` rises, each register ignores the first two rising edges of its own clock and loads from the third one onward.
- R10: With INVERT=1, every data bit is complemented on its way to the driven bus. With INVERT=0, data passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | A-to-B clock; its rising edge loads the A-side register |
| clk_ba | input | 1 | B-to-A clock; its rising edge loads the B-side register |
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| oe_n | input | 1 | Active-low output enable; 1 isolates both buses |
| dir | input | 1 | Direction: 0 drives bus A, 1 drives bus B |
| sel_ab | input | 1 | Source for bus B: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source for bus A: 0 live B, 1 stored B |
| a_in | input | W | Sensed level of bus A |
| b_in | input | W | Sensed level of bus B |
| a_pull | output | W | Pull-low enables for bus A |
| b_pull | output | W | Pull-low enables for bus B |

## Verification
Several properties are checked on every cycle. Isolation must release both buses. Only one bus may ever be pulled, and the undriven side must stay quiet in each direction. Each register must hold the value its own clock sampled at the previous edge, and the registers must stay cleared while their synchronised reset is still low. The bench's scenarios show the rest. A pattern captured in isolation must reappear later in a stored-data mode. The first two edges after reset must be swallowed. Wired-AND buses must interact correctly when a register samples a bus the block is itself pulling. The inverted data path is checked against the non-inverted one under the same stimulus.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;

  typedef enum logic [1:0] {
    XV_ISOLATE = 2'd0,
    XV_DRIVE_A = 2'd1,
    XV_DRIVE_B = 2'd2
  } xv_route_e;

  function automatic xv_route_e xv_decode(input logic oe_n, input logic dir);
    if (oe_n)     return XV_ISOLATE;
    else if (dir) return XV_DRIVE_B;
    else          return XV_DRIVE_A;
  endfunction

endpackage

// File: rtl/bus_xcvr_rst_sync.sv
module bus_xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_out_n
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[LAST-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_out_n = chain_q[LAST];

endmodule

// File: rtl/bus_xcvr_store.sv
module bus_xcvr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load_en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/bus_xcvr_path.sv
module bus_xcvr_path #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  input  logic         sel_stored,
  input  logic         drive,
  output logic [W-1:0] pull
);

  logic [W-1:0] picked;
  logic [W-1:0] level;

  always_comb picked = sel_stored ? stored : live;

  generate
    if (INVERT) begin : g_inv
      always_comb level = ~picked;
    end else begin : g_pass
      always_comb level = picked;
    end
  endgenerate

  // open-collector: a driven low level becomes an active pull
  always_comb pull = drive ? ~level : '0;

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int W           = 8,
  parameter bit INVERT      = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         rst_n,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_pull,
  output logic [W-1:0] b_pull
);

  import bus_xcvr_pkg::*;

  xv_route_e    route;
  logic         rst_ab_n;
  logic         rst_ba_n;
  logic [W-1:0] stored_a;
  logic [W-1:0] stored_b;
  logic         drive_a;
  logic         drive_b;

  always_comb begin
    route   = xv_decode(oe_n, dir);
    drive_a = (route == XV_DRIVE_A);
    drive_b = (route == XV_DRIVE_B);
  end

  bus_xcvr_rst_sync #(.STAGES(SYNC_STAGES)) u_sync_ab (
    .clk       (clk_ab),
    .rst_n     (rst_n),
    .rst_out_n (rst_ab_n)
  );

  bus_xcvr_rst_sync #(.STAGES(SYNC_STAGES)) u_sync_ba (
    .clk       (clk_ba),
    .rst_n     (rst_n),
    .rst_out_n (rst_ba_n)
  );

  // capture runs on every edge, independent of the output controls
  bus_xcvr_store #(.W(W)) u_store_a (
    .clk     (clk_ab),
    .rst_n   (rst_ab_n),
    .load_en (1'b1),
    .d       (a_in),
    .q       (stored_a)
  );

  bus_xcvr_store #(.W(W)) u_store_b (
    .clk     (clk_ba),
    .rst_n   (rst_ba_n),
    .load_en (1'b1),
    .d       (b_in),
    .q       (stored_b)
  );

  bus_xcvr_path #(.W(W), .INVERT(INVERT)) u_to_a (
    .live       (b_in),
    .stored     (stored_b),
    .sel_stored (sel_ba),
    .drive      (drive_a),
    .pull       (a_pull)
  );

  bus_xcvr_path #(.W(W), .INVERT(INVERT)) u_to_b (
    .live       (a_in),
    .stored     (stored_a),
    .sel_stored (sel_ab),
    .drive      (drive_b),
    .pull       (b_pull)
  );

endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int W = 8
) (
  input logic         clk_ab,
  input logic         clk_ba,
  input logic         rst_n,
  input logic         oe_n,
  input logic         dir,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_pull,
  input logic [W-1:0] b_pull,
  input logic [W-1:0] stored_a,
  input logic [W-1:0] stored_b,
  input logic         rst_ab_n,
  input logic         rst_ba_n
);

  a_r1_isolation: assert property (@(posedge clk_ab) disable iff (!rst_n)
    oe_n |-> (a_pull == '0 && b_pull == '0));

  a_r6_single_bus: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !((|a_pull) && (|b_pull)));

  a_r2_b_quiet_when_a_driven: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!oe_n && !dir) |-> (b_pull == '0));

  a_r4_a_quiet_when_b_driven: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!oe_n && dir) |-> (a_pull == '0));

  a_r7_capture_ab: assert property (@(posedge clk_ab) disable iff (!rst_n)
    rst_ab_n |=> (stored_a == $past(a_in)));

  a_r7_capture_ba: assert property (@(posedge clk_ba) disable iff (!rst_n)
    rst_ba_n |=> (stored_b == $past(b_in)));

  a_r9_hold_after_release_ab: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !rst_ab_n |-> (stored_a == '0));

  a_r9_hold_after_release_ba: assert property (@(posedge clk_ba) disable iff (!rst_n)
    !rst_ba_n |-> (stored_b == '0));

endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.W(W)) u_chk (
  .clk_ab   (clk_ab),
  .clk_ba   (clk_ba),
  .rst_n    (rst_n),
  .oe_n     (oe_n),
  .dir      (dir),
  .a_in     (a_in),
  .b_in     (b_in),
  .a_pull   (a_pull),
  .b_pull   (b_pull),
  .stored_a (stored_a),
  .stored_b (stored_b),
  .rst_ab_n (rst_ab_n),
  .rst_ba_n (rst_ba_n)
);

// File: tb/bus_xcvr_reg_test.sv
module bus_xcvr_reg_test;

  localparam int W = 8;

  logic         sys_clk = 1'b0;
  logic         rst_n;
  logic         en_ab, en_ba;
  logic         oe_n, dir, sel_ab, sel_ba;
  logic [W-1:0] a_ext, b_ext;
  logic         clk_ab, clk_ba;

  // index 0: non-inverting instance, index 1: inverting instance
  logic [W-1:0] a_pull [2];
  logic [W-1:0] b_pull [2];
  logic [W-1:0] a_bus  [2];
  logic [W-1:0] b_bus  [2];

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 sys_clk = ~sys_clk;

  assign clk_ab = sys_clk & en_ab;
  assign clk_ba = sys_clk & en_ba;

  // wired-AND buses with pull-ups
  always_comb begin
    for (int v = 0; v < 2; v++) begin
      a_bus[v] = a_ext & ~a_pull[v];
      b_bus[v] = b_ext & ~b_pull[v];
    end
  end

  bus_xcvr_reg #(.W(W), .INVERT(1'b0)) uut (
    .clk_ab (clk_ab), .clk_ba (clk_ba), .rst_n (rst_n),
    .oe_n (oe_n), .dir (dir), .sel_ab (sel_ab), .sel_ba (sel_ba),
    .a_in (a_bus[0]), .b_in (b_bus[0]),
    .a_pull (a_pull[0]), .b_pull (b_pull[0])
  );

  bus_xcvr_reg #(.W(W), .INVERT(1'b1)) uut_inv (
    .clk_ab (clk_ab), .clk_ba (clk_ba), .rst_n (rst_n),
    .oe_n (oe_n), .dir (dir), .sel_ab (sel_ab), .sel_ba (sel_ba),
    .a_in (a_bus[1]), .b_in (b_bus[1]),
    .a_pull (a_pull[1]), .b_pull (b_pull[1])
  );

  // ---------------- reference model ----------------
  logic [W-1:0] m_ra [2];
  logic [W-1:0] m_rb [2];
  int           cnt_ab, cnt_ba;
  logic [W-1:0] exp_ap [2];
  logic [W-1:0] exp_bp [2];
  logic [W-1:0] m_abus [2];
  logic [W-1:0] m_bbus [2];

  always_comb begin
    for (int v = 0; v < 2; v++) begin
      logic [W-1:0] msk;
      msk = (v == 1) ? '1 : '0;
      exp_ap[v] = '0;
      exp_bp[v] = '0;
      if (!oe_n && !dir) exp_ap[v] = ~((sel_ba ? m_rb[v] : b_ext) ^ msk);
      if (!oe_n &&  dir) exp_bp[v] = ~((sel_ab ? m_ra[v] : a_ext) ^ msk);
      m_abus[v] = a_ext & ~exp_ap[v];
      m_bbus[v] = b_ext & ~exp_bp[v];
    end
  end

  always @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < 2; v++) begin
        m_ra[v] <= '0;
        m_rb[v] <= '0;
      end
      cnt_ab <= 0;
      cnt_ba <= 0;
    end else begin
      if (en_ab) begin
        if (cnt_ab >= 2) for (int v = 0; v < 2; v++) m_ra[v] <= m_abus[v];
        else cnt_ab <= cnt_ab + 1;
      end
      if (en_ba) begin
        if (cnt_ba >= 2) for (int v = 0; v < 2; v++) m_rb[v] <= m_bbus[v];
        else cnt_ba <= cnt_ba + 1;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic check_vec(input string tag, input logic [W-1:0] act,
                           input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string mode_tag(input int v);
    string t;
    if (oe_n)        t = "R1";
    else if (!dir)   t = sel_ba ? "R3,R7,R8 stored B->A" : "R2 live B->A";
    else             t = sel_ab ? "R5,R7,R8 stored A->B" : "R4 live A->B";
    if (v == 1) t = {t, " R10 inverted"};
    return t;
  endfunction

  task automatic compare_all();
    for (int v = 0; v < 2; v++) begin
      check_vec({mode_tag(v), " a_pull"}, a_pull[v], exp_ap[v]);
      check_vec({mode_tag(v), " b_pull"}, b_pull[v], exp_bp[v]);
      checks++;
      if ((|a_pull[v]) && (|b_pull[v])) begin
        errors++;
        $display("FAIL R6 both buses pulled actual=%b/%b expected one zero",
                 a_pull[v], b_pull[v]);
      end
    end
  endtask

  always @(negedge sys_clk) begin
    if (rst_n === 1'b1) begin
      #1;
      compare_all();
    end
  end

  task automatic step(input logic i_oe_n, input logic i_dir,
                      input logic i_sab, input logic i_sba,
                      input logic i_eab, input logic i_eba,
                      input logic [W-1:0] i_a, input logic [W-1:0] i_b);
    @(negedge sys_clk);
    #2;
    oe_n = i_oe_n; dir = i_dir; sel_ab = i_sab; sel_ba = i_sba;
    en_ab = i_eab; en_ba = i_eba; a_ext = i_a; b_ext = i_b;
  endtask

  initial begin
    rst_n = 1'b0;
    oe_n = 1'b1; dir = 1'b0; sel_ab = 1'b0; sel_ba = 1'b0;
    en_ab = 1'b1; en_ba = 1'b1; a_ext = '1; b_ext = '1;
    repeat (3) @(posedge sys_clk);
    #1;
    // R9 reset state, R1 isolation during reset
    check_vec("R9 reset a_pull", a_pull[0], '0);
    check_vec("R9 reset b_pull", b_pull[0], '0);
    @(negedge sys_clk);
    rst_n = 1'b1;

    // R9: two edges after release are swallowed (patterns 5A/A5 ignored)
    step(1, 0, 0, 0, 1, 1, 8'h5A, 8'hA5);
    step(1, 0, 0, 0, 0, 0, 8'h5A, 8'hA5);
    // read back stored A: still zero, so every bit pulled (non-inverting)
    step(0, 1, 1, 0, 0, 0, 8'hFF, 8'hFF);
    @(negedge sys_clk); #1;
    check_vec("R9 stored A still zero after two edges", b_pull[0], 8'hFF);
    check_vec("R9 R10 stored A zero inverted", b_pull[1], 8'h00);
    step(0, 0, 0, 1, 0, 0, 8'hFF, 8'hFF);
    @(negedge sys_clk); #1;
    check_vec("R9 stored B still zero after two edges", a_pull[0], 8'hFF);

    // R8: capture in isolation, then read back
    step(1, 0, 0, 0, 1, 1, 8'h3C, 8'hC6);
    step(1, 1, 1, 1, 0, 0, 8'hFF, 8'hFF);
    @(negedge sys_clk); #1;
    check_vec("R1 isolation a_pull", a_pull[0], '0);
    check_vec("R1 isolation b_pull", b_pull[0], '0);
    step(0, 1, 1, 0, 0, 0, 8'hFF, 8'hFF);
    @(negedge sys_clk); #1;
    check_vec("R5 R8 stored A onto B", b_pull[0], ~8'h3C);
    check_vec("R5 R10 stored A inverted", b_pull[1], 8'h3C);
    step(0, 0, 0, 1, 0, 0, 8'hFF, 8'hFF);
    @(negedge sys_clk); #1;
    check_vec("R3 R8 stored B onto A", a_pull[0], ~8'hC6);

    // R2 / R4 live paths
    step(0, 0, 0, 0, 0, 0, 8'hFF, 8'h81);
    @(negedge sys_clk); #1;
    check_vec("R2 live B onto A", a_pull[0], 8'h7E);
    check_vec("R2 B released", b_pull[0], 8'h00);
    step(0, 1, 0, 0, 0, 0, 8'h0F, 8'hFF);
    @(negedge sys_clk); #1;
    check_vec("R4 live A onto B", b_pull[0], 8'hF0);
    check_vec("R10 live A inverted", b_pull[1], 8'h0F);

    // R7: capture while driving; A register samples the bus it is not driving
    step(0, 1, 0, 0, 1, 1, 8'h96, 8'hFF);
    step(0, 1, 1, 0, 0, 0, 8'hFF, 8'hFF);
    @(negedge sys_clk); #1;
    check_vec("R7 captured while B driven", b_pull[0], ~8'h96);

    // random traffic, compared every cycle by the model
    for (int n = 0; n < 3000; n++) begin
      step(($urandom_range(0, 3) == 0), $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom_range(0, 1),
           W'($urandom), W'($urandom));
    end
    @(negedge sys_clk); #3;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule